// File: doc/BRIEF.md
# Device Directory Pointer Register

This block is the 64-bit control register through which software picks how a translation unit finds device contexts and where the root of its directory table lives. A write asks for one of five modes: translation off, pass-through, or a directory of one, two or three levels. The block also carries the page number of the root table. The block legalizes each request against the level counts the instance supports. It refuses a jump from one table mode straight into another, and it raises a busy flag while an accepted configuration is being applied. Software polls the busy bit and trusts the readback only once the bit has cleared.

The readback shows the legalized request as soon as the write is accepted. The committed outputs are what a table walker would consume, and they switch to the new configuration in the same cycle that busy falls. An instance can tie the root page number to a fixed value, for example a page held on chip. Writes to that field then have no effect, and the fixed value is always the one read back.

Top module: `dir_ptr_reg`

## Requirements
- R1: After reset the readback word is zero (mode 0 = off, busy clear, page number zero), `mode_o` is 0 and `root_ppn_o` is 0.
- R2: The readback word carries the mode in bits 3:0, the busy flag in bit 4 and the root page number in bits 53:10. Every other bit reads as zero, whatever value was written to it.
- R3: Mode codes are 0 = off, 1 = pass-through, 2 = one level, 3 = two levels, 4 = three levels. `LEVEL_MASK` bit k enables code k+2. A write of a supported code is accepted, and the readback shows it in the cycle after the write edge.
- R4: A write of a level code whose mask bit is clear, or of any code from 5 to 15, is accepted as mode 0 (off). The readback never shows an unsupported code.
- R5: When the current mode is a table mode (code 2 or above) and a write requests a different code of 2 or above, the write is refused. Mode, page number and busy stay as they were.
- R6: An accepted write sets busy for exactly `BUSY_CYCLES` cycles, starting at the write edge. A rewrite of the same table mode with a new page number is accepted.
- R7: A write that arrives while busy is set is ignored. The readback mode and page number are unchanged.
- R8: `mode_o` and the committed page number take the new values at the edge where busy clears, and they hold steady while busy is set.
- R9: `root_ppn_o` shows the committed page number when the committed mode is a table mode, and shows zero when it is off or pass-through.
- R10: With `FIXED_PPN_EN` set, the page-number field always reads back `FIXED_PPN` and writes to it are ignored. A table mode then commits `FIXED_PPN` as its root.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, sampled on the rising edge |
| wr_data_i | input | 64 | Register write data |
| rd_data_o | output | 64 | Register readback word |
| busy_o | output | 1 | Configuration being applied |
| mode_o | output | 4 | Committed directory mode |
| root_ppn_o | output | 44 | Committed root page number, zero unless a table mode is committed |

## Verification
The readback mode and page number are due one edge after the write is sampled. Busy is high at that same point and stays high for exactly `BUSY_CYCLES` samples. The committed mode and root change only in the first sample where busy reads low. The bench drives writes on the falling edge and samples on the next falling edge, so every result is read half a cycle after the edge that produced it. It counts busy samples one by one instead of waiting a fixed time. Refused and ignored writes are checked at the first sample after their edge, and again once any pending busy has cleared.

// File: rtl/dir_ptr_pkg.sv
package dir_ptr_pkg;
  localparam int REG_W    = 64;
  localparam int MODE_W   = 4;
  localparam int BUSY_BIT = 4;
  localparam int PPN_LSB  = 10;
  localparam int PPN_W    = 44;
  localparam int PPN_MSB  = PPN_LSB + PPN_W - 1;
  localparam int NUM_LVL  = 3;
  localparam int NUM_CODE = 1 << MODE_W;

  localparam logic [MODE_W-1:0] MODE_OFF  = 4'd0;
  localparam logic [MODE_W-1:0] MODE_BARE = 4'd1;
  localparam logic [MODE_W-1:0] MODE_LVL1 = 4'd2;

  function automatic logic is_table(input logic [MODE_W-1:0] m);
    return m >= MODE_LVL1;
  endfunction
endpackage

// File: rtl/dir_ptr_legal.sv
module dir_ptr_legal
  import dir_ptr_pkg::*;
#(
  parameter logic [NUM_LVL-1:0] LEVEL_MASK = 3'b011
) (
  input  logic [MODE_W-1:0] req_mode_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  output logic              refuse_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [NUM_CODE-1:0] sup_vec;

  for (genvar m = 0; m < NUM_CODE; m++) begin : g_sup
    if (m < 2) begin : g_fixed
      assign sup_vec[m] = 1'b1;
    end else if (m < 2 + NUM_LVL) begin : g_lvl
      assign sup_vec[m] = LEVEL_MASK[m-2];
    end else begin : g_rsvd
      assign sup_vec[m] = 1'b0;
    end
  end

  always_comb begin
    // table-to-table hop must route through off or pass-through
    refuse_o = is_table(cur_mode_i) && is_table(req_mode_i) && (req_mode_i != cur_mode_i);
    mode_o   = sup_vec[req_mode_i] ? req_mode_i : MODE_OFF;
  end
endmodule

// File: rtl/dir_ptr_busy.sv
module dir_ptr_busy #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - LAST;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
endmodule

// File: rtl/dir_ptr_root.sv
module dir_ptr_root
  import dir_ptr_pkg::*;
#(
  parameter bit               FIXED_EN  = 1'b0,
  parameter logic [PPN_W-1:0] FIXED_PPN = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PPN_W-1:0] ppn_i,
  output logic [PPN_W-1:0] ppn_o
);
  if (FIXED_EN) begin : g_fixed
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, load_i, ppn_i};
    assign ppn_o     = FIXED_PPN;
  end else begin : g_store
    logic [PPN_W-1:0] ppn_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ppn_q <= '0;
      else if (load_i) ppn_q <= ppn_i;
    end
    assign ppn_o = ppn_q;
  end
endmodule

// File: rtl/dir_ptr_reg.sv
module dir_ptr_reg
  import dir_ptr_pkg::*;
#(
  parameter logic [NUM_LVL-1:0] LEVEL_MASK   = 3'b011,
  parameter int                 BUSY_CYCLES  = 4,
  parameter bit                 FIXED_PPN_EN = 1'b0,
  parameter logic [PPN_W-1:0]   FIXED_PPN    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              busy_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [PPN_W-1:0]  root_ppn_o
);
  logic [MODE_W-1:0] mode_q, cm_mode_q, legal_mode;
  logic [PPN_W-1:0]  ppn, cm_ppn_q;
  logic              refuse, accept, busy, done;
  logic              unused_wr;

  assign unused_wr = ^{wr_data_i[REG_W-1:PPN_MSB+1], wr_data_i[PPN_LSB-1:MODE_W]};

  dir_ptr_legal #(.LEVEL_MASK(LEVEL_MASK)) u_legal (
    .req_mode_i (wr_data_i[MODE_W-1:0]),
    .cur_mode_i (mode_q),
    .refuse_o   (refuse),
    .mode_o     (legal_mode)
  );

  assign accept = wr_en_i && !busy && !refuse;

  dir_ptr_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .busy_o  (busy),
    .done_o  (done)
  );

  dir_ptr_root #(.FIXED_EN(FIXED_PPN_EN), .FIXED_PPN(FIXED_PPN)) u_root (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .ppn_i  (wr_data_i[PPN_MSB:PPN_LSB]),
    .ppn_o  (ppn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= MODE_OFF;
    else if (accept) mode_q <= legal_mode;
  end

  // walker-facing copy moves only when the apply window closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cm_mode_q <= MODE_OFF;
      cm_ppn_q  <= '0;
    end else if (done) begin
      cm_mode_q <= mode_q;
      cm_ppn_q  <= ppn;
    end
  end

  always_comb begin
    rd_data_o                  = '0;
    rd_data_o[MODE_W-1:0]      = mode_q;
    rd_data_o[BUSY_BIT]        = busy;
    rd_data_o[PPN_MSB:PPN_LSB] = ppn;
  end

  assign busy_o     = busy;
  assign mode_o     = cm_mode_q;
  assign root_ppn_o = is_table(cm_mode_q) ? cm_ppn_q : '0;
endmodule

// File: rtl/dir_ptr_reg_chk.sv
module dir_ptr_reg_chk
  import dir_ptr_pkg::*;
#(
  parameter logic [NUM_LVL-1:0] LEVEL_MASK   = 3'b011,
  parameter bit                 FIXED_PPN_EN = 1'b0,
  parameter logic [PPN_W-1:0]   FIXED_PPN    = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              busy_o,
  input logic [MODE_W-1:0] mode_o,
  input logic [PPN_W-1:0]  root_ppn_o
);
  logic [NUM_CODE-1:0] sup_v;
  logic [MODE_W-1:0]   rd_mode, req_mode;
  logic [PPN_W-1:0]    rd_ppn;
  logic                unused_chk;

  assign sup_v      = {{(NUM_CODE-NUM_LVL-2){1'b0}}, LEVEL_MASK, 2'b11};
  assign rd_mode    = rd_data_o[MODE_W-1:0];
  assign rd_ppn     = rd_data_o[PPN_MSB:PPN_LSB];
  assign req_mode   = wr_data_i[MODE_W-1:0];
  assign unused_chk = ^{wr_data_i[REG_W-1:MODE_W]};

  a_r4_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_v[rd_mode]);

  a_r2_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1:PPN_MSB+1] == '0 && rd_data_o[PPN_LSB-1:BUSY_BIT+1] == '0);

  a_r7_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && wr_en_i |=> $stable(rd_mode) && $stable(rd_ppn));

  a_r5_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && wr_en_i && rd_mode >= 4'd2 && req_mode >= 4'd2 && req_mode != rd_mode
    |=> $stable(rd_mode) && $stable(rd_ppn) && !busy_o);

  a_r6_busy_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(mode_o)));

  a_r8_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> mode_o == rd_mode);

  a_r9_root_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o < 4'd2 |-> root_ppn_o == '0);

  a_r10_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    FIXED_PPN_EN |-> rd_ppn == FIXED_PPN);
endmodule

bind dir_ptr_reg dir_ptr_reg_chk #(
  .LEVEL_MASK  (LEVEL_MASK),
  .FIXED_PPN_EN(FIXED_PPN_EN),
  .FIXED_PPN   (FIXED_PPN)
) u_chk (.*);

// File: tb/dir_ptr_reg_bench.sv
module dir_ptr_reg_bench;
  localparam int NB = 4;
  localparam logic [43:0] FIX = 44'h0000_00AB_CDE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        we = 1'b0, we_f = 1'b0;
  logic [63:0] wd = '0, wd_f = '0;
  logic [63:0] rd, rd_f;
  logic        busy, busy_f;
  logic [3:0]  md, md_f;
  logic [43:0] rp, rp_f;

  int n_chk = 0;
  int n_fail = 0;

  dir_ptr_reg #(.LEVEL_MASK(3'b011), .BUSY_CYCLES(NB)) u_dir_ptr_reg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd), .busy_o(busy), .mode_o(md), .root_ppn_o(rp));

  dir_ptr_reg #(.LEVEL_MASK(3'b100), .BUSY_CYCLES(NB), .FIXED_PPN_EN(1'b1), .FIXED_PPN(FIX))
    u_dir_ptr_reg_fix (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we_f), .wr_data_i(wd_f),
    .rd_data_o(rd_f), .busy_o(busy_f), .mode_o(md_f), .root_ppn_o(rp_f));

  function automatic logic [63:0] word(input logic [43:0] p, input logic b, input logic [3:0] m);
    return {10'b0, p, 5'b0, b, m};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit fx, input logic [63:0] d);
    @(negedge clk);
    if (fx) begin we_f = 1'b1; wd_f = d; end
    else    begin we   = 1'b1; wd   = d; end
    @(negedge clk);
    we = 1'b0; we_f = 1'b0;
  endtask

  task automatic wait_idle(input bit fx);
    for (int i = 0; i < 50; i++) begin
      if (!(fx ? busy_f : busy)) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 readback", rd, 64'h0);
    check("R1 mode_o", 64'(md), 64'h0);
    check("R1 busy", 64'(busy), 64'h0);
    check("R1 root_ppn_o", 64'(rp), 64'h0);
  endtask

  task automatic t_busy_window();
    int n = 0;
    wr(0, word(44'h0, 1'b0, 4'd1));
    check("R3 bare readback", rd, word(44'h0, 1'b1, 4'd1));
    check("R8 mode_o held", 64'(md), 64'd0);
    while (busy && n < 20) begin
      if (n > 0) check("R8 mode_o stable while busy", 64'(md), 64'd0);
      n++;
      @(negedge clk);
    end
    check("R6 busy length", 64'(n), 64'(NB));
    check("R8 mode_o at busy fall", 64'(md), 64'd1);
    check("R9 root zero in bare", 64'(rp), 64'd0);
  endtask

  task automatic t_layout();
    logic [43:0] p = 44'hA5A_5A5A_5A5A;
    wr(0, {10'h3FF, p, 6'h3F, 4'd2});
    check("R2 layout with junk bits", rd, word(p, 1'b1, 4'd2));
    wait_idle(0);
    check("R2 idle readback", rd, word(p, 1'b0, 4'd2));
    check("R3 mode_o one level", 64'(md), 64'd2);
    check("R9 root in table mode", 64'(rp), 64'(p));
  endtask

  task automatic t_refuse();
    logic [43:0] q = 44'h123_4567_89AB;
    wr(0, word(q, 1'b0, 4'd3));
    check("R5 refused readback", rd, word(44'hA5A_5A5A_5A5A, 1'b0, 4'd2));
    @(negedge clk);
    check("R5 still idle", 64'(busy), 64'd0);
    check("R5 mode_o kept", 64'(md), 64'd2);
  endtask

  task automatic t_same_table();
    logic [43:0] q = 44'h123_4567_89AB;
    wr(0, word(q, 1'b0, 4'd2));
    check("R6 same-table rewrite busy", rd, word(q, 1'b1, 4'd2));
    wait_idle(0);
    check("R6 same-table root", 64'(rp), 64'(q));
  endtask

  task automatic t_busy_ignore();
    wr(0, word(44'h0, 1'b0, 4'd0));
    wr(0, word(44'h777, 1'b0, 4'd1));
    check("R7 write during busy ignored", {rd[63:5], rd[3:0]}, {word(44'h0, 1'b0, 4'd0)} >> 1);
    wait_idle(0);
    check("R7 after idle", rd, word(44'h0, 1'b0, 4'd0));
    check("R9 root zero in off", 64'(rp), 64'd0);
  endtask

  task automatic t_warl();
    wr(0, word(44'h55, 1'b0, 4'd4)); wait_idle(0);
    check("R4 unsupported level to off", 64'(rd[3:0]), 64'd0);
    wr(0, word(44'h0, 1'b0, 4'd1)); wait_idle(0);
    wr(0, word(44'h66, 1'b0, 4'd9)); wait_idle(0);
    check("R4 reserved code to off", 64'(rd[3:0]), 64'd0);
    check("R8 mode_o off after reserved", 64'(md), 64'd0);
    wr(0, word(44'h99, 1'b0, 4'd3)); wait_idle(0);
    check("R3 two level accepted", rd, word(44'h99, 1'b0, 4'd3));
    check("R9 two level root", 64'(rp), 64'h99);
  endtask

  task automatic t_fixed();
    check("R10 fixed at reset", rd_f, word(FIX, 1'b0, 4'd0));
    wr(1, word(44'hFFF_0000_1111, 1'b0, 4'd2)); wait_idle(1);
    check("R4 fixed unsupported level", rd_f, word(FIX, 1'b0, 4'd0));
    wr(1, word(44'hFFF_0000_1111, 1'b0, 4'd4));
    check("R10 fixed ppn ignores write", rd_f, word(FIX, 1'b1, 4'd4));
    wait_idle(1);
    check("R10 fixed root committed", 64'(rp_f), 64'(FIX));
    check("R3 three level mode_o", 64'(md_f), 64'd4);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy_window();
    t_layout();
    t_refuse();
    t_same_table();
    t_busy_ignore();
    t_warl();
    t_fixed();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule